// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block drives and samples a small bank of general-purpose pins through a 32-bit word-addressed register bus. For each pin, software sets an output value and a direction. It reads back the level of the pin after that level has been synchronised into the clock domain.

Every pin can raise an interrupt. Its trigger condition is chosen per pin: a rising edge, a falling edge, either edge, a high level or a low level. A detected condition sets a sticky pending bit, but only while the pin's enable bit is set. Software masks and unmasks pins through two separate write-one registers: one sets mask bits and the other clears them. One combined interrupt line goes high while any pending pin is both enabled and unmasked. Software can return every control register to its default by writing 1 and then 0 to a soft-reset register.

The pin count is a parameter. It is 12 by default, and 8 gives the reduced variant. Register bits at or above the pin count are dropped on write and read as zero.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every readable register reads zero, and `pin_out`, `pin_oe` and `irq_out` are low.
- R2: A write to the output-value register (word address 0) is latched. It reads back and appears on `pin_out`, and bits at or above the pin count read as zero.
- R3: The direction register (word address 2) drives `pin_oe` bit for bit (1 = output, 0 = input), and only its low pin-count bits are kept.
- R4: The input register (word address 1) returns each pin's level after a two-flop synchroniser, at most three clocks after the pin changes.
- R5: Each pin has a 3-bit trigger code in the low three bits of a 4-bit nibble at bit 4×(pin mod 8). Pins 0–7 use word address 3 and pins 8–11 use word address 4. The fourth bit of each nibble, and the nibbles of absent pins, read as zero.
- R6: Trigger codes 000 (falling edge), 001 (rising edge) and 1xx (either edge) set a pin's pending bit when its synchronised level changes in that direction. A change in any other direction does not set it.
- R7: Trigger codes 010 (low level) and 011 (high level) set the pending bit on every clock the level holds, so a clear during an active level has no lasting effect.
- R8: A pin whose enable bit (word address 5) is 0 never gains a pending bit.
- R9: Writing 1s to word address 6 sets those mask bits, and writing 1s to word address 7 clears them. Bits written as 0 leave the mask unchanged, and both addresses read back the mask.
- R10: `irq_out` is high exactly when some pending bit is also enabled and unmasked. Pending state (word address 8) is held regardless of mask and enable.
- R11: Writing 1s to word address 9 clears those pending bits, unless the same clock sets them again.
- R12: Writing 1 to bit 0 of word address 10 arms the soft reset. A later write of 0 to that bit returns all control, mode, enable, mask and pending state to zero. A write of 0 while unarmed changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per asserted clock |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_out | output | NUM_PINS | Latched output values |
| pin_oe | output | NUM_PINS | Output enables from the direction register |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `bus_we` and `bus_addr` are stable around each rising edge and carry exactly one write per asserted clock. They also assume `rst_n` is released away from the clock edge. The bench meets this by changing every bus and pin input only on the falling edge. It holds each pin level for at least four clocks, so the synchroniser, the previous-value stage and the pending register have all settled before a read. Level-triggered pins are returned to their inactive level before their pending bits are cleared.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned CODE_W = 3;
    localparam int unsigned NIB_W  = 4;
    localparam int unsigned PINS_PER_MODE_REG = BUS_W / NIB_W;

    typedef enum logic [ADDR_W-1:0] {
        A_DOUT    = 4'd0,
        A_DIN     = 4'd1,
        A_DIR     = 4'd2,
        A_MODE_LO = 4'd3,
        A_MODE_HI = 4'd4,
        A_EN      = 4'd5,
        A_MSET    = 4'd6,
        A_MCLR    = 4'd7,
        A_PEND    = 4'd8,
        A_PCLR    = 4'd9,
        A_SRST    = 4'd10
    } reg_addr_e;

    // Trigger codes: bit 2 selects either-edge, otherwise bits 1:0 select.
    localparam logic [1:0] TRIG_FALL = 2'b00;
    localparam logic [1:0] TRIG_RISE = 2'b01;
    localparam logic [1:0] TRIG_LOW  = 2'b10;
    localparam logic [1:0] TRIG_HIGH = 2'b11;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stable;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PINS-1:0]        lvl_i,
    input  logic [NUM_PINS*CODE_W-1:0] code_i,
    output logic [NUM_PINS-1:0]        evt_o
);
    logic [NUM_PINS-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [CODE_W-1:0] code;
        logic rise, fall;
        assign code = code_i[p*CODE_W +: CODE_W];
        assign rise = lvl_i[p] & ~prev_q[p];
        assign fall = ~lvl_i[p] & prev_q[p];
        always_comb begin
            if (code[2]) begin
                evt_o[p] = rise | fall;
            end else begin
                unique case (code[1:0])
                    TRIG_FALL: evt_o[p] = fall;
                    TRIG_RISE: evt_o[p] = rise;
                    TRIG_LOW:  evt_o[p] = ~lvl_i[p];
                    default:   evt_o[p] = lvl_i[p];
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS = 12  // 1..16 (two mode registers)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_out
);
    localparam int unsigned MODE_W = NUM_PINS * CODE_W;

    typedef struct packed {
        logic [NUM_PINS-1:0] dout;
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] en;
        logic [NUM_PINS-1:0] mask;
        logic [NUM_PINS-1:0] pend;
        logic [MODE_W-1:0]   mode;
        logic                armed;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [NUM_PINS-1:0] lvl_s, evt, wbits;
    logic srst_fire;
    logic wdata_unused;

    assign wbits        = bus_wdata[NUM_PINS-1:0];
    assign wdata_unused = ^bus_wdata;

    gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(lvl_s)
    );

    gpio_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_s), .code_i(st_q.mode), .evt_o(evt)
    );

    always_comb begin
        st_d      = st_q;
        srst_fire = bus_we && (bus_addr == A_SRST) && !bus_wdata[0] && st_q.armed;
        if (bus_we) begin
            case (bus_addr)
                A_DOUT:    st_d.dout = wbits;
                A_DIR:     st_d.dir  = wbits;
                A_EN:      st_d.en   = wbits;
                A_MSET:    st_d.mask = st_q.mask | wbits;
                A_MCLR:    st_d.mask = st_q.mask & ~wbits;
                A_PCLR:    st_d.pend = st_q.pend & ~wbits;
                A_SRST:    st_d.armed = bus_wdata[0];
                A_MODE_LO, A_MODE_HI: begin
                    for (int i = 0; i < NUM_PINS; i++) begin
                        if ((i / PINS_PER_MODE_REG) == ((bus_addr == A_MODE_HI) ? 1 : 0))
                            st_d.mode[i*CODE_W +: CODE_W] =
                                bus_wdata[(i % PINS_PER_MODE_REG)*NIB_W +: CODE_W];
                    end
                end
                default: ;
            endcase
        end
        st_d.pend = st_d.pend | (evt & st_q.en);
        if (srst_fire) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DOUT:         bus_rdata[NUM_PINS-1:0] = st_q.dout;
            A_DIN:          bus_rdata[NUM_PINS-1:0] = lvl_s;
            A_DIR:          bus_rdata[NUM_PINS-1:0] = st_q.dir;
            A_EN:           bus_rdata[NUM_PINS-1:0] = st_q.en;
            A_MSET, A_MCLR: bus_rdata[NUM_PINS-1:0] = st_q.mask;
            A_PEND:         bus_rdata[NUM_PINS-1:0] = st_q.pend;
            A_SRST:         bus_rdata[0] = st_q.armed;
            A_MODE_LO, A_MODE_HI: begin
                for (int i = 0; i < NUM_PINS; i++) begin
                    if ((i / PINS_PER_MODE_REG) == ((bus_addr == A_MODE_HI) ? 1 : 0))
                        bus_rdata[(i % PINS_PER_MODE_REG)*NIB_W +: CODE_W] =
                            st_q.mode[i*CODE_W +: CODE_W];
                end
            end
            default: ;
        endcase
    end

    assign pin_out = st_q.dout;
    assign pin_oe  = st_q.dir;
    assign irq_out = |(st_q.pend & st_q.en & ~st_q.mask);

    // R8: a pending bit never rises on a pin that was disabled
    a_r8_disabled_stays_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend & ~$past(st_q.pend) & ~$past(st_q.en)) == '0);

    // R9: bits written to the mask-set address are masked afterwards
    a_r9_mask_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == A_MSET && !srst_fire) |->
        ((st_q.mask & $past(wbits)) == $past(wbits)));

    // R11: cleared pending bits stay clear unless re-detected in that clock
    a_r11_clear_wins_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == A_PCLR && !srst_fire) |->
        ((st_q.pend & $past(wbits & ~(evt & st_q.en))) == '0));

    // R12: an armed 1-then-0 sequence leaves every control field at zero
    a_r12_soft_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        $past(srst_fire) |-> (st_q == '0));

    // R10: the combined line is never high with nothing pending
    a_r10_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (st_q.pend != '0));
endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
    localparam int unsigned N = 12;
    localparam int K_RD = 0, K_IRQ = 1, K_OUT = 2, K_OE = 3;

    logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, irq_out;
    logic [3:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] pin_in = '0, pin_out, pin_oe;

    typedef struct {
        string       req;
        int          kind;
        logic [31:0] exp;
    } item_t;
    item_t sb_q[$];
    logic mon_req = 1'b0;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.NUM_PINS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // Monitor: pops expected items and compares against the live outputs
    initial forever begin
        @(negedge clk);
        #1;
        if (mon_req && sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_IRQ:   act = {31'd0, irq_out};
                K_OUT:   act = {20'd0, pin_out};
                K_OE:    act = {20'd0, pin_oe};
                default: act = bus_rdata;
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", it.req, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic expect_val(input int kind, input logic [3:0] a,
                              input logic [31:0] e, input string req);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.req = req; it.kind = kind; it.exp = e;
        sb_q.push_back(it);
        mon_req = 1'b1;
        @(negedge clk);
        mon_req = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string req);
        expect_val(K_RD, a, e, req);
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd0, 0, "R1"); rd(4'd2, 0, "R1"); rd(4'd3, 0, "R1");
        rd(4'd5, 0, "R1"); rd(4'd6, 0, "R1"); rd(4'd8, 0, "R1");
        expect_val(K_IRQ, 0, 0, "R1"); expect_val(K_OE, 0, 0, "R1");
        expect_val(K_OUT, 0, 0, "R1");
        // R2 output latch, upper bits dropped
        wr(4'd0, 32'hFFFF_FA5A);
        rd(4'd0, 32'h0000_0A5A, "R2"); expect_val(K_OUT, 0, 32'hA5A, "R2");
        // R3 direction
        wr(4'd2, 32'hFFFF_F0F0);
        rd(4'd2, 32'h0000_00F0, "R3"); expect_val(K_OE, 0, 32'h0F0, "R3");
        // R4 synchronised input
        @(negedge clk); pin_in = 12'h123;
        repeat (3) @(negedge clk);
        rd(4'd1, 32'h123, "R4");
        // R5 mode nibble layout
        wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, 32'h7777_7777, "R5");
        wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, 32'h0000_7777, "R5");
        // Setup: pin0 rise, pin1 fall, pin2 both, pin3 high, pin4 low
        set_pins(12'h010);
        wr(4'd3, 32'h0002_3401); wr(4'd4, 32'h0);
        wr(4'd5, 32'h01F); wr(4'd9, 32'hFFF);
        rd(4'd8, 0, "R6");
        // R6 edges
        set_pins(12'h015);
        rd(4'd8, 32'h005, "R6"); expect_val(K_IRQ, 0, 1, "R10");
        wr(4'd9, 32'h005);
        rd(4'd8, 0, "R11"); expect_val(K_IRQ, 0, 0, "R10");
        set_pins(12'h012);
        rd(4'd8, 32'h004, "R6");
        set_pins(12'h010);
        rd(4'd8, 32'h006, "R6");
        wr(4'd9, 32'hFFF);
        // R7 level triggers
        set_pins(12'h018);
        rd(4'd8, 32'h008, "R7");
        wr(4'd9, 32'h008);
        rd(4'd8, 32'h008, "R7");
        set_pins(12'h000);
        rd(4'd8, 32'h018, "R7");
        set_pins(12'h010);
        wr(4'd9, 32'h018);
        rd(4'd8, 0, "R7");
        // R8 disabled pin5 falling edge
        set_pins(12'h030); set_pins(12'h010);
        rd(4'd8, 0, "R8"); expect_val(K_IRQ, 0, 0, "R8");
        // R9 / R10 masking
        set_pins(12'h011);
        rd(4'd8, 32'h001, "R6"); expect_val(K_IRQ, 0, 1, "R10");
        wr(4'd6, 32'h001);
        rd(4'd6, 32'h001, "R9"); expect_val(K_IRQ, 0, 0, "R9");
        wr(4'd7, 32'h000); rd(4'd7, 32'h001, "R9");
        wr(4'd6, 32'h000); rd(4'd6, 32'h001, "R9");
        wr(4'd7, 32'h001);
        rd(4'd6, 0, "R9"); expect_val(K_IRQ, 0, 1, "R9");
        wr(4'd5, 32'h000);
        expect_val(K_IRQ, 0, 0, "R10"); rd(4'd8, 32'h001, "R10");
        wr(4'd5, 32'h01F);
        // R12 soft reset
        wr(4'd10, 32'h0); rd(4'd0, 32'hA5A, "R12");
        wr(4'd10, 32'h1); rd(4'd10, 32'h1, "R12"); rd(4'd0, 32'hA5A, "R12");
        wr(4'd10, 32'h0);
        rd(4'd0, 0, "R12"); rd(4'd2, 0, "R12"); rd(4'd3, 0, "R12");
        rd(4'd5, 0, "R12"); rd(4'd8, 0, "R12"); rd(4'd10, 0, "R12");
        expect_val(K_OE, 0, 0, "R12"); expect_val(K_IRQ, 0, 0, "R12");
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule